// File: doc/BRIEF.md
# Rotor Stall and Reverse-Rotation Guard

This block watches the synchronised three-bit Hall code of a three-phase brushless motor. It tells the commutation logic when to stop driving. It catches two faults. The first is a rotor that stops moving while it is being driven. The second is a rotor that keeps turning the wrong way. A stall latches an inhibit on the three high-side (PWM-switched) outputs. A sustained reverse latches an inhibit on all six outputs. All timing is counted in clock ticks set by parameters.

Once set, a protection latch stays set. Only two things clear it: a stop request held for a set number of ticks, or a zero-duty indication held for a much shorter release time. The release time defaults to one hundred-and-fiftieth of the stall time. Rotation direction comes from the order in which the six valid Hall codes arrive, relative to the direction select. Reverse is judged after two backward steps in a row. Once reverse is judged, drive is still allowed for one stall period before the all-off latch is set. This grace window also covers a motor that is already turning backward when drive begins.

The direction select, stop, brake, zero-duty and reverse-enable inputs are assumed to be synchronous to the clock.

Top module: `motor_guard`

## Requirements
- R1: After rst_ni is released, with reverse protection disabled, both hs_inhibit_o and all_off_o are low.
- R2: The motor counts as driven when stop_i, brake_i and zero_duty_i are all low. hs_inhibit_o rises after the LOCK_TICKS-th consecutive rising edge at which the motor is driven and the position has not moved.
- R3: The valid Hall codes {in1,in2,in3} are 101, 100, 110, 010, 011 and 001, which are positions 0 to 5. A change to a different valid code counts as motion and restarts the stall count. The codes 000 and 111 are ignored and leave the stored position unchanged.
- R4: While brake_i is high, stall detection is suspended and its count restarts. A stall is flagged only after LOCK_TICKS driven edges that follow the release of the brake.
- R5: Once set, hs_inhibit_o and the reverse latch stay set for as long as stop_i and zero_duty_i are both low.
- R6: stop_i held high for STOP_TICKS consecutive edges clears both latches and the backward-step count. A shorter stop clears nothing.
- R7: zero_duty_i held high for REL_TICKS consecutive edges clears both latches. REL_TICKS defaults to LOCK_TICKS/150.
- R8: With dir_i low, forward motion is position 0→1→…→5→0. With dir_i high, forward motion is the opposite order.
- R9: Each step to the adjacent backward position adds to a backward count, which saturates at 2. A forward step clears the count. Reverse is judged while the count is 2.
- R10: While reverse is judged and the motor is driven, all_off_o latches high after LOCK_TICKS such edges, but only if rev_en_i is high at the edge where the latch is set.
- R11: Whenever rev_en_i and zero_duty_i are both high, all_off_o is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hall_i | input | 3 | Synchronised Hall code {in1,in2,in3} |
| dir_i | input | 1 | Direction select |
| stop_i | input | 1 | Stop request |
| brake_i | input | 1 | Short-circuit brake request |
| zero_duty_i | input | 1 | Commanded duty is 0% |
| rev_en_i | input | 1 | Reverse protection enable |
| hs_inhibit_o | output | 1 | Turn off the high-side outputs (stall) |
| all_off_o | output | 1 | Turn off all six outputs |

## Verification
The assertions check on every cycle that a stall latch only rises after a driven cycle and only falls after a stop or zero-duty cycle. They also check that latches hold while neither clear source is present, that a reverse latch needs the enable and a judged reverse, that a forward step drops the reverse judgment, and that the tick counters stay in range. Only the bench scenarios can show the exact tick counts behind each latch and each clear. The same goes for the restart caused by motion and by braking, the blindness to the codes 000 and 111, and the direction-dependent sequence decoding.

// File: rtl/mg_pkg.sv
package mg_pkg;
  localparam int unsigned HALL_POS = 6;

  typedef struct packed {
    logic       ok;
    logic [2:0] idx;
  } hall_pos_t;

  // Position along the commutation order; 000/111 are not positions
  function automatic hall_pos_t decode_hall(input logic [2:0] code);
    hall_pos_t p;
    p.ok = 1'b1;
    case (code)
      3'b101:  p.idx = 3'd0;
      3'b100:  p.idx = 3'd1;
      3'b110:  p.idx = 3'd2;
      3'b010:  p.idx = 3'd3;
      3'b011:  p.idx = 3'd4;
      3'b001:  p.idx = 3'd5;
      default: begin p.ok = 1'b0; p.idx = 3'd0; end
    endcase
    return p;
  endfunction

  function automatic logic [2:0] pos_next(input logic [2:0] i);
    return (i == 3'(HALL_POS - 1)) ? 3'd0 : i + 3'd1;
  endfunction

  function automatic logic [2:0] pos_prev(input logic [2:0] i);
    return (i == 3'd0) ? 3'(HALL_POS - 1) : i - 3'd1;
  endfunction
endpackage

// File: rtl/mg_tick_timer.sv
module mg_tick_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic done_o
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign done_o = run_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !run_i)   cnt_q <= '0;
    else if (cnt_q != LAST)     cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0); // R6
endmodule

// File: rtl/mg_hall_track.sv
module mg_hall_track
  import mg_pkg::*;
#(
  parameter int unsigned BWD_STEPS = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] hall_i,
  input  logic       dir_i,
  input  logic       clr_i,
  output logic       motion_o,
  output logic       rev_seen_o
);
  localparam int unsigned CW = $clog2(BWD_STEPS + 1);
  localparam logic [CW-1:0] CMAX = CW'(BWD_STEPS);

  hall_pos_t    cur;
  logic [2:0]   pos_q;
  logic         have_q;
  logic [CW-1:0] bwd_q;
  logic         up, down, fwd_step, bwd_step;

  assign cur      = decode_hall(hall_i);
  assign motion_o = cur.ok && (!have_q || cur.idx != pos_q);
  assign up       = have_q && cur.ok && (cur.idx == pos_next(pos_q));
  assign down     = have_q && cur.ok && (cur.idx == pos_prev(pos_q));
  assign fwd_step = dir_i ? down : up;
  assign bwd_step = dir_i ? up : down;
  assign rev_seen_o = (bwd_q == CMAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      have_q <= 1'b0;
    end else if (cur.ok) begin
      pos_q  <= cur.idx;
      have_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       bwd_q <= '0;
    else if (clr_i || fwd_step)        bwd_q <= '0;
    else if (bwd_step && bwd_q != CMAX) bwd_q <= bwd_q + 1'b1;
  end

  AST_BWD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bwd_q <= CMAX); // R9
  AST_FWD_DROPS_REV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_step |=> !rev_seen_o); // R9
  AST_BAD_CODE_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cur.ok |=> $stable(pos_q)); // R3
endmodule

// File: rtl/motor_guard.sv
module motor_guard #(
  parameter int unsigned LOCK_TICKS = 1500,
  parameter int unsigned REL_TICKS  = (LOCK_TICKS / 150 > 0) ? LOCK_TICKS / 150 : 1,
  parameter int unsigned STOP_TICKS = 20,
  parameter int unsigned BWD_STEPS  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] hall_i,
  input  logic       dir_i,
  input  logic       stop_i,
  input  logic       brake_i,
  input  logic       zero_duty_i,
  input  logic       rev_en_i,
  output logic       hs_inhibit_o,
  output logic       all_off_o
);
  logic driving, motion, rev_seen;
  logic lock_done, rev_done, stop_done, rel_done, release_all;
  logic lock_q, rev_q;

  assign driving     = !stop_i && !brake_i && !zero_duty_i;
  assign release_all = stop_done || rel_done;

  mg_hall_track #(.BWD_STEPS(BWD_STEPS)) i_track (
    .clk_i, .rst_ni, .hall_i, .dir_i,
    .clr_i(stop_done), .motion_o(motion), .rev_seen_o(rev_seen)
  );

  mg_tick_timer #(.LIMIT(LOCK_TICKS)) i_lock_tmr (
    .clk_i, .rst_ni, .run_i(driving), .clr_i(motion), .done_o(lock_done)
  );

  mg_tick_timer #(.LIMIT(LOCK_TICKS)) i_rev_tmr (
    .clk_i, .rst_ni, .run_i(driving && rev_seen), .clr_i(1'b0), .done_o(rev_done)
  );

  mg_tick_timer #(.LIMIT(STOP_TICKS)) i_stop_tmr (
    .clk_i, .rst_ni, .run_i(stop_i), .clr_i(1'b0), .done_o(stop_done)
  );

  mg_tick_timer #(.LIMIT(REL_TICKS)) i_rel_tmr (
    .clk_i, .rst_ni, .run_i(zero_duty_i), .clr_i(1'b0), .done_o(rel_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      rev_q  <= 1'b0;
    end else if (release_all) begin
      lock_q <= 1'b0;
      rev_q  <= 1'b0;
    end else begin
      if (lock_done)             lock_q <= 1'b1;
      if (rev_done && rev_en_i)  rev_q  <= 1'b1;
    end
  end

  assign hs_inhibit_o = lock_q;
  assign all_off_o    = rev_q || (rev_en_i && zero_duty_i);

  AST_LOCK_NEEDS_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_inhibit_o) |-> $past(!stop_i && !brake_i && !zero_duty_i)); // R2
  AST_LATCH_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_inhibit_o && !stop_i && !zero_duty_i) |=> hs_inhibit_o); // R5
  AST_REV_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rev_q && !stop_i && !zero_duty_i) |=> rev_q); // R5
  AST_CLEAR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_inhibit_o) |-> $past(stop_i || zero_duty_i)); // R6
  AST_REV_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rev_q) |-> $past(rev_en_i && rev_seen)); // R10
endmodule

// File: tb/test_motor_guard.sv
module test_motor_guard;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK = 1500;
  localparam int REL  = 10;
  localparam int STP  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hall = 3'b101;
  logic dir = 1'b0, stop = 1'b1, brake = 1'b0, zero = 1'b0, rev_en = 1'b0;
  logic hs_inh, all_off;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  motor_guard #(.LOCK_TICKS(LOCK), .REL_TICKS(REL), .STOP_TICKS(STP)) i_motor_guard (
    .clk_i(clk), .rst_ni(rst_n), .hall_i(hall), .dir_i(dir), .stop_i(stop),
    .brake_i(brake), .zero_duty_i(zero), .rev_en_i(rev_en),
    .hs_inhibit_o(hs_inh), .all_off_o(all_off)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_all();
    stop = 1'b1; step(STP + 1); stop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 hs", hs_inh, 1'b0);
    chk("R1 all", all_off, 1'b0);
  endtask

  task automatic t_lock();
    clear_all();
    step(LOCK - 1); chk("R2 early", hs_inh, 1'b0);
    step(1);        chk("R2 stall", hs_inh, 1'b1);
    step(7);        chk("R5 hold", hs_inh, 1'b1);
  endtask

  task automatic t_stop();
    stop = 1'b1; step(STP - 1); stop = 1'b0;
    step(1); chk("R6 short stop", hs_inh, 1'b1);
    stop = 1'b1; step(STP - 1); chk("R6 before", hs_inh, 1'b1);
    step(1); chk("R6 cleared", hs_inh, 1'b0);
    stop = 1'b0;
  endtask

  task automatic t_motion();
    clear_all();
    step(LOCK - 2); hall = 3'b100;
    step(LOCK); chk("R3 restart", hs_inh, 1'b0);
    step(1);    chk("R3 stall after move", hs_inh, 1'b1);
    clear_all();
    step(5); hall = 3'b111;
    step(LOCK - 6); chk("R3 invalid early", hs_inh, 1'b0);
    hall = 3'b100;
    step(1); chk("R3 invalid ignored", hs_inh, 1'b1);
  endtask

  task automatic t_brake();
    clear_all();
    step(LOCK - 2); brake = 1'b1;
    step(3); chk("R4 braking", hs_inh, 1'b0);
    brake = 1'b0;
    step(LOCK - 1); chk("R4 restart", hs_inh, 1'b0);
    step(1); chk("R4 stall", hs_inh, 1'b1);
  endtask

  task automatic t_release();
    zero = 1'b1;
    step(REL - 1); chk("R7 before", hs_inh, 1'b1);
    step(1);       chk("R7 cleared", hs_inh, 1'b0);
    zero = 1'b0;
  endtask

  task automatic t_zero_off();
    rev_en = 1'b1; zero = 1'b1; #1;
    chk("R11 forced", all_off, 1'b1);
    rev_en = 1'b0; #1;
    chk("R11 disabled", all_off, 1'b0);
    zero = 1'b0; #1;
  endtask

  task automatic t_reverse();
    rev_en = 1'b1; dir = 1'b0; clear_all();
    hall = 3'b101; step(1);   // pos1 -> pos0
    hall = 3'b001; step(1);   // pos0 -> pos5
    step(LOCK - 1); chk("R10 grace", all_off, 1'b0);
    step(1);        chk("R10 latched", all_off, 1'b1);
    step(4);        chk("R5 rev hold", all_off, 1'b1);
    clear_all();    chk("R6 rev cleared", all_off, 1'b0);
  endtask

  task automatic t_fwd_clear();
    rev_en = 1'b1; clear_all();
    hall = 3'b011; step(1);   // back
    hall = 3'b001; step(1);   // forward
    hall = 3'b011; step(1);   // back
    step(LOCK + 3); chk("R9 forward clears", all_off, 1'b0);
    clear_all();
  endtask

  task automatic t_no_enable();
    rev_en = 1'b0; clear_all();
    hall = 3'b010; step(1);
    hall = 3'b110; step(1);
    step(LOCK + 3); chk("R10 disabled", all_off, 1'b0);
    clear_all();
  endtask

  task automatic t_dir_high();
    rev_en = 1'b1; dir = 1'b1; clear_all();
    hall = 3'b010; step(1);   // pos2 -> pos3 is backward
    hall = 3'b011; step(1);
    step(LOCK - 1); chk("R8 dir1 grace", all_off, 1'b0);
    step(1);        chk("R8 dir1 reverse", all_off, 1'b1);
    clear_all();
    hall = 3'b010; step(1);   // pos4 -> pos3 forward
    hall = 3'b110; step(1);
    step(LOCK + 3); chk("R8 dir1 forward", all_off, 1'b0);
    clear_all();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_lock();
    t_stop();
    t_motion();
    t_brake();
    t_release();
    t_zero_off();
    t_reverse();
    t_fwd_clear();
    t_no_enable();
    t_dir_high();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule